// File: doc/BRIEF.md
# Charge Safety Timer Controller

This block limits how long a battery charger may stay in each charging phase. It runs one timer for the precharge phase and one for the fast-charge phase, which covers both constant current and constant voltage. When a timer reaches its limit before the phase ends, the block disables charging, sets a sticky fault flag and emits one interrupt pulse of fixed length. The timer counts ticks of a prescaled timebase that comes from outside the block.

A 2-bit duration code selects the fast-charge limit. The precharge limit is always a quarter of that limit. An optional doubling mode slows the fast-charge count to half rate while an external current-reduction loop limits the charge. While the system draws from the battery (supplement mode), the count is frozen. A fall back from fast charge into precharge restarts the count. Writing a different duration code also restarts the count.

Top module: `chg_safety_timer`

## Requirements
- R1: After reset, `chg_dis`, `fault_flag` and `irq` are 0.
- R2: Phase encoding is 0 idle, 1 precharge, 2 constant current, 3 constant voltage, 4 done. In precharge, the tick that brings the accepted-tick count to a quarter of the selected fast-charge limit raises the fault.
- R3: In phases 2 and 3, the tick that brings the accepted-tick count to the selected fast-charge limit raises the fault. Moving from phase 2 to phase 3 does not restart the count.
- R4: A fault sets `chg_dis` and `fault_flag` on the clock edge that accepts the expiring tick. It also drives `irq` high for exactly PULSE_US microseconds of clock cycles (CLK_HZ/1e6*PULSE_US cycles), once per fault.
- R5: `dur_code` 0..3 selects limit LIM0..LIM3. A change of `dur_code` while in precharge or fast charge restarts the count from zero.
- R6: With `dbl_en` and `loop_active` both 1 in phase 2 or 3, only every second tick is counted. In precharge the rate is never halved.
- R7: Entering precharge from any other phase restarts the count. Entering phase 2 or 3 from a phase that is neither restarts it from zero.
- R8: While `supp_active` is 1, ticks are not counted and the count is kept. Counting resumes from the kept value afterwards.
- R9: `chg_dis` and `fault_flag` stay set until `flag_clr` is pulsed or the phase is idle. Further ticks cause no second pulse.
- R10: Ticks are not counted in the idle or done phase, nor while `chg_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled timebase strobe, one cycle wide |
| phase | input | 3 | Charging phase code (see R2) |
| chg_en | input | 1 | Charging enabled |
| supp_active | input | 1 | Supplement mode active, freezes the count |
| loop_active | input | 1 | A current-reduction loop is limiting charge |
| dur_code | input | 2 | Fast-charge duration select |
| dbl_en | input | 1 | Allows half-rate fast-charge counting |
| flag_clr | input | 1 | Host clear of fault flag and disable |
| chg_dis | output | 1 | Charging disabled by timer fault |
| fault_flag | output | 1 | Sticky timer-fault flag |
| irq | output | 1 | Interrupt pulse on fault |

## Verification
The hardest situations to reach from the ports are the ones where the count must carry over or restart at the right moment. These are a supplement-mode freeze in the middle of a fast-charge run, a fall back to precharge and back to fast charge, and a duration change partway through a run. In each, the elapsed time can only be seen through when the fault finally fires. The stimulus resets its own tick tally exactly where the design should restart, then walks each such history. The scoreboard predicts the tally at which `irq` must rise and the pulse width that follows, so a wrong carry-over or a missed restart moves the fault to the wrong tick.

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int CNT_W    = 16,
  parameter int LIM0     = 10800,
  parameter int LIM1     = 18000,
  parameter int LIM2     = 32400,
  parameter int LIM3     = 54000,
  parameter int CLK_HZ   = 250_000_000,
  parameter int PULSE_US = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] phase,
  input  logic       chg_en,
  input  logic       supp_active,
  input  logic       loop_active,
  input  logic [1:0] dur_code,
  input  logic       dbl_en,
  input  logic       flag_clr,
  output logic       chg_dis,
  output logic       fault_flag,
  output logic       irq
);
  localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * PULSE_US;
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [2:0] PH_IDLE = 3'd0, PH_PRE = 3'd1, PH_CC = 3'd2, PH_CV = 3'd3;

  logic [CNT_W-1:0] cnt, lim_fc, lim_now;
  logic [2:0]       phase_q;
  logic [1:0]       dur_q;
  logic             half_ph;
  logic [PW-1:0]    pcnt;

  wire is_pre   = (phase == PH_PRE);
  wire is_fast  = (phase == PH_CC) || (phase == PH_CV);
  wire was_pre  = (phase_q == PH_PRE);
  wire was_fast = (phase_q == PH_CC) || (phase_q == PH_CV);
  wire timing   = is_pre || is_fast;

  always_comb begin
    case (dur_code)
      2'd0:    lim_fc = CNT_W'(LIM0);
      2'd1:    lim_fc = CNT_W'(LIM1);
      2'd2:    lim_fc = CNT_W'(LIM2);
      default: lim_fc = CNT_W'(LIM3);
    endcase
  end
  assign lim_now = is_pre ? (lim_fc >> 2) : lim_fc;

  wire restart   = (is_pre && !was_pre) || (is_fast && !was_fast) ||
                   (timing && (dur_code != dur_q));
  wire halfmode  = is_fast && dbl_en && loop_active;
  wire cand      = tick && timing && chg_en && !chg_dis && !supp_active && !restart;
  wire step      = cand && (!halfmode || half_ph);
  wire fault_now = step && ({1'b0, cnt} + 1'b1 >= {1'b0, lim_now});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; phase_q <= PH_IDLE; dur_q <= 2'd0; half_ph <= 1'b0;
      chg_dis <= 1'b0; fault_flag <= 1'b0; pcnt <= '0;
    end else begin
      phase_q <= phase;
      dur_q   <= dur_code;
      if (restart) begin
        cnt <= '0; half_ph <= 1'b0;
      end else begin
        if (step && !fault_now) cnt <= cnt + 1'b1;
        if (cand && halfmode) half_ph <= ~half_ph;
      end
      if (fault_now) begin
        chg_dis <= 1'b1; fault_flag <= 1'b1;
      end else if (flag_clr || phase == PH_IDLE) begin
        chg_dis <= 1'b0; fault_flag <= 1'b0;
      end
      if (fault_now) pcnt <= PW'(PULSE_CYC);
      else if (pcnt != '0) pcnt <= pcnt - 1'b1;
    end
  end
  assign irq = (pcnt != '0);

  assert_irq_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (fault_flag && chg_dis));
  assert_fault_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> (irq && chg_dis && fault_flag));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_dis && !flag_clr && phase != PH_IDLE) |=> chg_dis);
  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (supp_active && !restart) |=> $stable(cnt));
  assert_no_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing || !chg_en) |=> $stable(cnt));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: tb/tb_chg_safety_timer.sv
module tb_chg_safety_timer;
  localparam int PULSE = 128;
  logic clk = 0, rst_n = 0, tick = 0, chg_en = 1, supp_active = 0, loop_active = 0;
  logic dbl_en = 0, flag_clr = 0;
  logic [2:0] phase = 0;
  logic [1:0] dur_code = 0;
  logic chg_dis, fault_flag, irq;
  int checks = 0, errors = 0, tk = 0;
  int expq[$];
  string tagq[$];

  always #2 clk = ~clk;

  chg_safety_timer #(.CNT_W(8), .LIM0(16), .LIM1(32), .LIM2(64), .LIM3(128),
    .CLK_HZ(1_000_000), .PULSE_US(128)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase), .chg_en(chg_en),
    .supp_active(supp_active), .loop_active(loop_active), .dur_code(dur_code),
    .dbl_en(dbl_en), .flag_clr(flag_clr), .chg_dis(chg_dis),
    .fault_flag(fault_flag), .irq(irq));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_fault(string req, int at_tick);
    tagq.push_back(req);
    expq.push_back(at_tick);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1; tk++;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic idle_wait(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_phase(logic [2:0] p);
    @(negedge clk); phase = p; tk = 0;
    @(negedge clk);
  endtask

  // monitor: pops expected fault tick and checks pulse width
  initial begin
    logic prev = 0;
    int w = 0;
    string t;
    forever begin
      @(negedge clk);
      if (irq && !prev) begin
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: unexpected irq, actual 1 expected 0");
        end else begin
          t = tagq.pop_front();
          check(t, tk, expq.pop_front());
        end
        w = 1;
      end else if (irq) w++;
      else if (prev) check("R4 width", w, PULSE);
      prev = irq;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_wait(3);
    check("R1 chg_dis", chg_dis, 0);
    check("R1 fault_flag", fault_flag, 0);
    check("R1 irq", irq, 0);
    @(negedge clk); rst_n = 1;

    // R2 precharge limit 16/4 = 4
    go_phase(1); expect_fault("R2", 4); ticks(6);
    idle_wait(140);
    check("R9 hold dis", chg_dis, 1);
    check("R9 hold flag", fault_flag, 1);
    go_phase(0);
    check("R9 idle clears", chg_dis + fault_flag, 0);

    // R3 fast limit spans CC and CV
    go_phase(2); expect_fault("R3", 16); ticks(8);
    @(negedge clk); phase = 3;
    ticks(10); idle_wait(140);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R9 clr clears", chg_dis + fault_flag, 0);
    go_phase(0);

    // R5 table and restart on code change
    dur_code = 1; go_phase(1); expect_fault("R5 pre code1", 8); ticks(8);
    idle_wait(140); go_phase(0);
    dur_code = 3; go_phase(1); expect_fault("R5 pre code3", 32); ticks(32);
    idle_wait(140); go_phase(0);
    dur_code = 0; go_phase(2); ticks(10);
    @(negedge clk); dur_code = 1; tk = 0;
    expect_fault("R5 restart", 32); ticks(34);
    idle_wait(140); go_phase(0);

    // R6 half rate in fast, not in pre
    dur_code = 0; dbl_en = 1; loop_active = 1;
    go_phase(2); expect_fault("R6 half", 32); ticks(33);
    idle_wait(140); go_phase(0);
    go_phase(1); expect_fault("R6 pre full", 4); ticks(4);
    idle_wait(140); go_phase(0);
    dbl_en = 0; loop_active = 0;

    // R7 fall back restarts
    dur_code = 1; go_phase(2); ticks(20);
    go_phase(1); ticks(5);
    go_phase(2); expect_fault("R7", 32); ticks(32);
    idle_wait(140); go_phase(0);

    // R8 supplement freeze
    dur_code = 0; go_phase(2); ticks(6);
    @(negedge clk); supp_active = 1; ticks(20);
    @(negedge clk); supp_active = 0;
    expect_fault("R8", 36); ticks(12);
    idle_wait(140); go_phase(0);

    // R10 no counting in done or with charging disabled
    go_phase(4); ticks(50);
    check("R10 done irq", irq, 0);
    check("R10 done dis", chg_dis, 0);
    go_phase(2); chg_en = 0; ticks(50);
    check("R10 chg_en irq", irq, 0);
    @(negedge clk); chg_en = 1; tk = 0;
    expect_fault("R10 resume", 16); ticks(16);
    idle_wait(140);
    ticks(40); idle_wait(5);
    check("R9 no second pulse", irq, 0);
    go_phase(0);

    check("scoreboard drained", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule